// File: doc/BRIEF.md
# Character CRT Controller Register Interface

This block is the processor-facing side of a character-cell CRT controller. A processor first writes a slot number into a select register, and then either writes or reads the data port. Writes go through a per-slot mask before they are stored. Each stored value is presented continuously as a decoded timing parameter, ready for the raster timing logic that sits beside this block. Register 3 holds two independent fields. Register 8 is decoded into an interlace mode and a skew selection.

Most slots are write-only, and reading them returns all ones. Only the start and cursor address bytes and the two light pen bytes read back. A light pen strobe captures the live refresh address into the two light pen bytes and raises a flag in the status byte. Reading either captured byte lowers that flag again. The parameter `HAS_STATUS` picks one of two variants. With `HAS_STATUS` set, there is a status byte that also reports the VSYNC level, and there is a general-purpose 8-bit scratch slot. With `HAS_STATUS` clear, status reads and that slot both return all ones.

Top module: `crtc_regfile`

## Requirements
- R1: After a synchronous reset, every stored slot, the light pen bytes, the light pen flag, the select register and `rdata` are zero.
- R2: A pulse on `sel_we` loads `wdata[4:0]` into the select register. `wdata[7:5]` is discarded.
- R3: Register 3 drives `hsync_width` from bits 3:0 and `vsync_lines` from bits 7:4.
- R4: Writes are masked as follows. Slots 4, 6 and 7 keep bits 6:0. Slots 5, 9, 10 and 11 keep bits 4:0. Slots 0, 1, 2, 3 and 8 keep all eight bits. Each decoded output shows the masked value.
- R5: Slots 12 and 14 keep bits 5:0 and slots 13 and 15 keep all eight bits. `start_addr` is {slot12[5:0], slot13} and `cursor_addr` is {slot14[5:0], slot15}.
- R6: Register 8 bits 1:0 decode to `interlace` as follows: 01 gives 1 (sync only), 11 gives 2 (sync and video), and any other value gives 0 (off). `skew` equals bits 5:4.
- R7: A data read returns the stored value for slots 12 to 17. All other slots return 0xFF, except slot 31 on the status variant.
- R8: A light pen strobe stores {2'b00, refresh_addr[13:8]} in slot 16 and refresh_addr[7:0] in slot 17, and it sets status bit 6.
- R9: A data read of slot 16 or 17 clears status bit 6. A strobe in the same cycle wins, so the flag stays set.
- R10: With `HAS_STATUS`=1, a status read returns bit 6 as the light pen flag and bit 5 as the current `vsync`, with all other bits zero. With `HAS_STATUS`=0, a status read returns 0xFF.
- R11: With `HAS_STATUS`=1, slot 31 is a plain 8-bit read/write slot. Data writes to slots 16 to 31 are otherwise ignored.
- R12: `rdata` is registered. It takes the read result on the clock edge after the strobe and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_we | input | 1 | Load the select register from `wdata` |
| data_we | input | 1 | Write `wdata` into the selected slot |
| data_re | input | 1 | Read the selected slot into `rdata` |
| stat_re | input | 1 | Read the status byte into `rdata` |
| wdata | input | 8 | Write data |
| lpen_stb | input | 1 | Light pen strobe |
| refresh_addr | input | 14 | Live refresh address |
| vsync | input | 1 | Current vertical sync level |
| rdata | output | 8 | Registered read data |
| h_total | output | 8 | Horizontal total |
| h_disp | output | 8 | Horizontal displayed characters |
| h_sync_pos | output | 8 | Horizontal sync position |
| hsync_width | output | 4 | Horizontal sync width |
| vsync_lines | output | 4 | Vertical sync line count |
| v_total | output | 8 | Vertical total (7 bits used) |
| v_adjust | output | 8 | Vertical adjust (5 bits used) |
| v_disp | output | 8 | Vertical displayed rows (7 bits used) |
| v_sync_pos | output | 8 | Vertical sync position (7 bits used) |
| interlace | output | 2 | Decoded interlace mode |
| skew | output | 2 | Display skew selection |
| max_row | output | 8 | Last scan line of a row (5 bits used) |
| cursor_start | output | 8 | Cursor start line (5 bits used) |
| cursor_end | output | 8 | Cursor end line (5 bits used) |
| start_addr | output | 14 | Display start address |
| cursor_addr | output | 14 | Cursor address |

## Verification
The hardest case to reach is a light pen strobe that lands in the same cycle as a read of a captured byte. That read must return the old capture while the flag stays set. The stimulus selects slot 16 and then raises the strobe and the data read on the same edge. A status read then confirms that bit 6 is still set, and a second read of slot 16 shows the new capture. Masking, which most slots never show on readback, is observed through the decoded outputs after writing all ones to every slot.

// File: rtl/crtc_regs_pkg.sv
package crtc_regs_pkg;
  typedef enum logic [1:0] {
    ILACE_OFF        = 2'd0,
    ILACE_SYNC       = 2'd1,
    ILACE_SYNC_VIDEO = 2'd2
  } ilace_e;

  localparam int SLOT_W       = 5;
  localparam int SLOT_PEN_HI  = 16;
  localparam int SLOT_PEN_LO  = 17;
  localparam int SLOT_SCRATCH = 31;

  // Keep-mask for a writable slot; hi_bits is the width of the address high bytes.
  function automatic logic [7:0] slot_mask(input int idx, input int hi_bits);
    case (idx)
      4, 6, 7:      slot_mask = 8'h7F;
      5, 9, 10, 11: slot_mask = 8'h1F;
      12, 14:       slot_mask = 8'((1 << hi_bits) - 1);
      default:      slot_mask = 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/crtc_cfg_bank.sv
module crtc_cfg_bank
  import crtc_regs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NREG   = 16,
  parameter int RA_W   = 14
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [SLOT_W-1:0]             sel,
  input  logic [DATA_W-1:0]             wdata,
  output logic [NREG-1:0][DATA_W-1:0]   cfg
);
  localparam int HI_BITS = RA_W - 8;

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    localparam logic [DATA_W-1:0] MASK = DATA_W'(slot_mask(g, HI_BITS));
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg[g] <= '0;
      end else if (we && sel == SLOT_W'(g)) begin
        cfg[g] <= wdata & MASK;
      end
    end
  end
endmodule

// File: rtl/crtc_lpen.sv
module crtc_lpen #(
  parameter int DATA_W = 8,
  parameter int RA_W   = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb,
  input  logic              clr,
  input  logic [RA_W-1:0]   ra,
  output logic [DATA_W-1:0] pen_hi,
  output logic [DATA_W-1:0] pen_lo,
  output logic              flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pen_hi <= '0;
      pen_lo <= '0;
      flag   <= 1'b0;
    end else begin
      if (stb) begin
        pen_hi <= DATA_W'(ra >> 8);
        pen_lo <= ra[7:0];
      end
      if (stb)      flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/crtc_regfile.sv
module crtc_regfile
  import crtc_regs_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int NREG       = 16,
  parameter int RA_W       = 14,
  parameter bit HAS_STATUS = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_we,
  input  logic              data_we,
  input  logic              data_re,
  input  logic              stat_re,
  input  logic [DATA_W-1:0] wdata,
  input  logic              lpen_stb,
  input  logic [RA_W-1:0]   refresh_addr,
  input  logic              vsync,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] h_total,
  output logic [DATA_W-1:0] h_disp,
  output logic [DATA_W-1:0] h_sync_pos,
  output logic [3:0]        hsync_width,
  output logic [3:0]        vsync_lines,
  output logic [DATA_W-1:0] v_total,
  output logic [DATA_W-1:0] v_adjust,
  output logic [DATA_W-1:0] v_disp,
  output logic [DATA_W-1:0] v_sync_pos,
  output logic [1:0]        interlace,
  output logic [1:0]        skew,
  output logic [DATA_W-1:0] max_row,
  output logic [DATA_W-1:0] cursor_start,
  output logic [DATA_W-1:0] cursor_end,
  output logic [RA_W-1:0]   start_addr,
  output logic [RA_W-1:0]   cursor_addr
);
  localparam int HI_BITS = RA_W - 8;
  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  logic [SLOT_W-1:0]           sel;
  logic [NREG-1:0][DATA_W-1:0] cfg;
  logic [DATA_W-1:0]           pen_hi, pen_lo, scratch, rd_mux, stat_byte;
  logic                        lpen_flag, pen_clr;
  ilace_e                      ilace;

  always_ff @(posedge clk) begin
    if (rst)         sel <= '0;
    else if (sel_we) sel <= wdata[SLOT_W-1:0];
  end

  crtc_cfg_bank #(.DATA_W(DATA_W), .NREG(NREG), .RA_W(RA_W)) u_bank (
    .clk(clk), .rst(rst), .we(data_we), .sel(sel), .wdata(wdata), .cfg(cfg)
  );

  assign pen_clr = data_re && (sel == SLOT_W'(SLOT_PEN_HI) || sel == SLOT_W'(SLOT_PEN_LO));

  crtc_lpen #(.DATA_W(DATA_W), .RA_W(RA_W)) u_lpen (
    .clk(clk), .rst(rst), .stb(lpen_stb), .clr(pen_clr), .ra(refresh_addr),
    .pen_hi(pen_hi), .pen_lo(pen_lo), .flag(lpen_flag)
  );

  if (HAS_STATUS) begin : g_scratch
    always_ff @(posedge clk) begin
      if (rst) scratch <= '0;
      else if (data_we && sel == SLOT_W'(SLOT_SCRATCH)) scratch <= wdata;
    end
    always_comb begin
      stat_byte    = '0;
      stat_byte[6] = lpen_flag;
      stat_byte[5] = vsync;
    end
  end else begin : g_no_scratch
    assign scratch   = ALL_ONES;
    assign stat_byte = ALL_ONES;
  end

  always_comb begin
    case (sel)
      5'd12, 5'd13, 5'd14, 5'd15: rd_mux = cfg[sel[3:0]];
      SLOT_W'(SLOT_PEN_HI):       rd_mux = pen_hi;
      SLOT_W'(SLOT_PEN_LO):       rd_mux = pen_lo;
      SLOT_W'(SLOT_SCRATCH):      rd_mux = scratch;
      default:                    rd_mux = ALL_ONES;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata <= '0;
    else if (stat_re) rdata <= stat_byte;
    else if (data_re) rdata <= rd_mux;
  end

  always_comb begin
    case (cfg[8][1:0])
      2'b01:   ilace = ILACE_SYNC;
      2'b11:   ilace = ILACE_SYNC_VIDEO;
      default: ilace = ILACE_OFF;
    endcase
  end

  assign h_total      = cfg[0];
  assign h_disp       = cfg[1];
  assign h_sync_pos   = cfg[2];
  assign hsync_width  = cfg[3][3:0];
  assign vsync_lines  = cfg[3][7:4];
  assign v_total      = cfg[4];
  assign v_adjust     = cfg[5];
  assign v_disp       = cfg[6];
  assign v_sync_pos   = cfg[7];
  assign interlace    = ilace;
  assign skew         = cfg[8][5:4];
  assign max_row      = cfg[9];
  assign cursor_start = cfg[10];
  assign cursor_end   = cfg[11];
  assign start_addr   = {cfg[12][HI_BITS-1:0], cfg[13]};
  assign cursor_addr  = {cfg[14][HI_BITS-1:0], cfg[15]};
endmodule

// File: rtl/crtc_regfile_chk.sv
module crtc_regfile_chk #(
  parameter int DATA_W     = 8,
  parameter bit HAS_STATUS = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              sel_we,
  input logic              data_re,
  input logic              stat_re,
  input logic              lpen_stb,
  input logic [4:0]        sel,
  input logic              lpen_flag,
  input logic [DATA_W-1:0] rdata
);
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !sel_we |=> $stable(sel)); // R2

  AST_LOW_SLOT_FF: assert property (@(posedge clk) disable iff (rst)
    (data_re && !stat_re && sel < 5'd12) |=> rdata == '1); // R7

  AST_PEN_SETS: assert property (@(posedge clk) disable iff (rst)
    lpen_stb |=> lpen_flag); // R8

  AST_PEN_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (data_re && !lpen_stb && (sel == 5'd16 || sel == 5'd17)) |=> !lpen_flag); // R9

  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (rst)
    (!data_re && !lpen_stb) |=> $stable(lpen_flag)); // R9

  AST_RDATA_KEEP: assert property (@(posedge clk) disable iff (rst)
    (!data_re && !stat_re) |=> $stable(rdata)); // R12

  if (!HAS_STATUS) begin : g_nostat
    AST_NOSTAT_FF: assert property (@(posedge clk) disable iff (rst)
      stat_re |=> rdata == '1); // R10
  end
endmodule

bind crtc_regfile crtc_regfile_chk #(.DATA_W(DATA_W), .HAS_STATUS(HAS_STATUS)) u_chk (
  .clk(clk), .rst(rst), .sel_we(sel_we), .data_re(data_re), .stat_re(stat_re),
  .lpen_stb(lpen_stb), .sel(sel), .lpen_flag(lpen_flag), .rdata(rdata)
);

// File: tb/crtc_regfile_tb.sv
module crtc_regfile_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic sel_we = 0, data_we = 0, data_re = 0, stat_re = 0, lpen_stb = 0, vsync = 0;
  logic [7:0]  wdata = '0;
  logic [13:0] refresh_addr = '0;
  logic [7:0]  rdata, rdata0;
  logic [7:0]  h_total, h_disp, h_sync_pos, v_total, v_adjust, v_disp, v_sync_pos;
  logic [7:0]  max_row, cursor_start, cursor_end;
  logic [3:0]  hsync_width, vsync_lines;
  logic [1:0]  interlace, skew;
  logic [13:0] start_addr, cursor_addr;
  logic [7:0]  x0_a, x0_b, x0_c, x0_d, x0_e, x0_f, x0_g, x0_h, x0_i, x0_j;
  logic [3:0]  x0_k, x0_l;
  logic [1:0]  x0_m, x0_n;
  logic [13:0] x0_o, x0_p;

  always #(CLK_PERIOD/2) clk = ~clk;

  crtc_regfile #(.HAS_STATUS(1'b1)) u_dut (
    .clk(clk), .rst(rst), .sel_we(sel_we), .data_we(data_we), .data_re(data_re),
    .stat_re(stat_re), .wdata(wdata), .lpen_stb(lpen_stb), .refresh_addr(refresh_addr),
    .vsync(vsync), .rdata(rdata), .h_total(h_total), .h_disp(h_disp),
    .h_sync_pos(h_sync_pos), .hsync_width(hsync_width), .vsync_lines(vsync_lines),
    .v_total(v_total), .v_adjust(v_adjust), .v_disp(v_disp), .v_sync_pos(v_sync_pos),
    .interlace(interlace), .skew(skew), .max_row(max_row), .cursor_start(cursor_start),
    .cursor_end(cursor_end), .start_addr(start_addr), .cursor_addr(cursor_addr)
  );

  crtc_regfile #(.HAS_STATUS(1'b0)) u_dut0 (
    .clk(clk), .rst(rst), .sel_we(sel_we), .data_we(data_we), .data_re(data_re),
    .stat_re(stat_re), .wdata(wdata), .lpen_stb(lpen_stb), .refresh_addr(refresh_addr),
    .vsync(vsync), .rdata(rdata0), .h_total(x0_a), .h_disp(x0_b),
    .h_sync_pos(x0_c), .hsync_width(x0_k), .vsync_lines(x0_l),
    .v_total(x0_d), .v_adjust(x0_e), .v_disp(x0_f), .v_sync_pos(x0_g),
    .interlace(x0_m), .skew(x0_n), .max_row(x0_h), .cursor_start(x0_i),
    .cursor_end(x0_j), .start_addr(x0_o), .cursor_addr(x0_p)
  );

  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       arm = 0;

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: a strobe seen at a rising edge means rdata is due at the next falling edge.
  always @(posedge clk) arm <= data_re | stat_re;
  always @(negedge clk) begin
    if (arm && exp_q.size() > 0) chk(tag_q.pop_front(), {8'h00, rdata}, {8'h00, exp_q.pop_front()});
  end

  task automatic sel_slot(logic [7:0] v);
    sel_we = 1; wdata = v; @(negedge clk); sel_we = 0;
  endtask
  task automatic wr(logic [7:0] idx, logic [7:0] v);
    sel_slot(idx);
    data_we = 1; wdata = v; @(negedge clk); data_we = 0;
  endtask
  task automatic rd(logic [7:0] idx, logic [7:0] exp, string tag);
    sel_slot(idx);
    exp_q.push_back(exp); tag_q.push_back(tag);
    data_re = 1; @(negedge clk); data_re = 0;
  endtask
  task automatic rd_stat(logic [7:0] exp, string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    stat_re = 1; @(negedge clk); stat_re = 0;
  endtask
  task automatic strobe(logic [13:0] ra);
    refresh_addr = ra; lpen_stb = 1; @(negedge clk); lpen_stb = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 rdata", {8'h00, rdata}, 16'h0000);
    chk("R1 start_addr", {2'b00, start_addr}, 16'h0000);
    chk("R1 h_total", {8'h00, h_total}, 16'h0000);
    rd_stat(8'h00, "R1 status");
    rd(8'd16, 8'h00, "R1 pen hi");

    // R4 R5 all-ones writes through the masks
    for (int i = 0; i < 16; i++) wr(8'(i), 8'hFF);
    chk("R4 h_total", {8'h00, h_total}, 16'h00FF);
    chk("R4 v_total", {8'h00, v_total}, 16'h007F);
    chk("R4 v_adjust", {8'h00, v_adjust}, 16'h001F);
    chk("R4 v_disp", {8'h00, v_disp}, 16'h007F);
    chk("R4 v_sync_pos", {8'h00, v_sync_pos}, 16'h007F);
    chk("R4 max_row", {8'h00, max_row}, 16'h001F);
    chk("R4 cursor_start", {8'h00, cursor_start}, 16'h001F);
    chk("R4 cursor_end", {8'h00, cursor_end}, 16'h001F);
    chk("R5 start_addr", {2'b00, start_addr}, 16'h3FFF);
    rd(8'd12, 8'h3F, "R5 slot12");
    rd(8'd15, 8'hFF, "R5 slot15");
    wr(8'd14, 8'h2B); wr(8'd15, 8'hC4);
    chk("R5 cursor_addr", {2'b00, cursor_addr}, 16'h2BC4);

    // R2 upper select bits dropped: 0xEC selects slot 12
    rd(8'hEC, 8'h3F, "R2 select low bits");

    // R3 split register
    wr(8'd3, 8'hA5);
    chk("R3 hsync_width", {12'h000, hsync_width}, 16'h0005);
    chk("R3 vsync_lines", {12'h000, vsync_lines}, 16'h000A);

    // R6 interlace decode and skew
    wr(8'd8, 8'h01); chk("R6 ilace 01", {14'h0, interlace}, 16'd1);
    wr(8'd8, 8'h03); chk("R6 ilace 11", {14'h0, interlace}, 16'd2);
    wr(8'd8, 8'h02); chk("R6 ilace 10", {14'h0, interlace}, 16'd0);
    wr(8'd8, 8'h31);
    chk("R6 skew", {14'h0, skew}, 16'd3);
    chk("R6 ilace with skew", {14'h0, interlace}, 16'd1);

    // R7 readback window
    rd(8'd0, 8'hFF, "R7 slot0");
    rd(8'd4, 8'hFF, "R7 slot4");
    rd(8'd11, 8'hFF, "R7 slot11");
    rd(8'd18, 8'hFF, "R7 slot18");
    rd(8'd13, 8'hFF, "R7 slot13");

    // R11 writes to 16..30 ignored
    wr(8'd16, 8'h55); rd(8'd16, 8'h00, "R11 slot16 write ignored");
    wr(8'd20, 8'h55); rd(8'd20, 8'hFF, "R11 slot20");

    // R8 R9 light pen
    strobe(14'h2A5C);
    rd_stat(8'h40, "R8 flag set");
    rd(8'd17, 8'h5C, "R8 pen lo");
    rd_stat(8'h00, "R9 cleared by slot17");
    strobe(14'h1234);
    rd(8'd16, 8'h12, "R8 pen hi");
    rd_stat(8'h00, "R9 cleared by slot16");
    strobe(14'h0F77);
    sel_slot(8'd16);
    exp_q.push_back(8'h0F); tag_q.push_back("R9 read with strobe old value");
    refresh_addr = 14'h3ABC; lpen_stb = 1; data_re = 1;
    @(negedge clk); lpen_stb = 0; data_re = 0;
    rd_stat(8'h40, "R9 strobe wins over clear");
    rd(8'd16, 8'h3A, "R9 new capture");

    // R10 status with vsync, and the no-status variant
    vsync = 1;
    rd_stat(8'h20, "R10 vsync bit");
    chk("R10 no-status variant", {8'h00, rdata0}, 16'h00FF);
    vsync = 0;

    // R11 scratch slot
    wr(8'd31, 8'h9C);
    rd(8'd31, 8'h9C, "R11 scratch");
    chk("R11 no-status variant slot31", {8'h00, rdata0}, 16'h00FF);

    // R12 rdata holds without reads
    wr(8'd13, 8'h11);
    repeat (3) @(negedge clk);
    chk("R12 rdata held", {8'h00, rdata}, 16'h009C);

    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule